// File: doc/BRIEF.md
# Two-Level Page Translation Unit

This block turns 32-bit linear addresses into physical addresses for one process at a time. A small fully associative translation cache answers repeated pages without touching memory. A miss starts a two-level walk through in-memory tables: first a directory entry, then a table entry. Each is fetched as one 32-bit word through a simple read port. The result is written into the cache and returned to the requester.

A base register holds the physical page that contains the current process's directory. Loading a new base value switches to another address space and empties the cache. As a result, the same linear address can resolve to a different frame after the switch. An entry whose valid bit is clear ends the walk with a fault, and a fault is never cached. Requests and responses use valid/ready handshakes, and only one translation is in flight at a time.

Top module: `pgw_xlate`

## Requirements
- R1: The first read of a walk is issued at word address {base[31:12], la[31:22], 2'b00}, where la is the request's linear address and base is the current base register.
- R2: When the directory entry has bit 0 set, the second read is issued at {pde[31:12], la[21:12], 2'b00}. When the table entry has bit 0 set, the response is {pte[31:12], la[11:0]} with the fault flag low. Entry bits 11:1 never reach the result.
- R3: A directory entry with bit 0 clear ends the walk after exactly one read, with the fault flag high and a physical address of zero.
- R4: A table entry with bit 0 clear gives a response with the fault flag high and a physical address of zero, after two reads.
- R5: A faulting walk writes nothing into the cache, so repeating the same address walks the tables again.
- R6: A request whose page number (bits 31:12) is in the cache gets its response on the cycle after acceptance, with no memory read. The result is the cached frame joined with the new offset.
- R7: Two different page numbers that map to the same physical frame can both stay in the cache and both hit.
- R8: A base register write empties the cache in that same cycle, and the block refuses a request during that cycle. Later walks use the new base.
- R9: A successful walk fills the lowest-numbered empty slot among the 4 slots. When all slots are full, slots are replaced in round-robin order starting at slot 0. Cache hits do not advance this order.
- R10: A response stays valid with a stable address and fault flag until it is accepted. No new request is taken while a translation is in flight or a response is waiting.
- R11: After reset, the request side is ready, no response is valid, no memory read is pending, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_we | input | 1 | Load the base register and empty the cache |
| base_wdata | input | 32 | New directory base (bits 31:12 used) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can take a request |
| req_laddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, zero on fault |
| rsp_fault | output | 1 | Walk hit an invalid entry |
| mem_req | output | 1 | One-cycle word read strobe |
| mem_addr | output | 32 | Byte address of the word read |
| mem_rvalid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Returned word |

## Verification
The bench first fills all four slots, then forces evictions. It probes which pages are still resident by counting memory reads. If the design skipped empty slots, let hits advance the replacement pointer, or started round-robin at the wrong slot, the bench would see a walk where it expects a hit. Two pages that share one frame are kept resident together; a design that treated them as a conflict would evict one of them. After a failed directory or table lookup, the same address is requested again to catch a fault that was cached. Addresses already cached under the old base are translated again after a base switch; a design that does not empty the cache on the switch would return the stale frame instead of walking the new tables.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 12;
  localparam int IDX_W  = 10;
  localparam int VPN_W  = ADDR_W - OFF_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RQ,
    ST_DIR_WT,
    ST_TAB_RQ,
    ST_TAB_WT,
    ST_RSP
  } walk_st_e;

  // word address of the directory entry for a linear address
  function automatic logic [ADDR_W-1:0] dir_rd_addr(input logic [ADDR_W-1:0] base,
                                                    input logic [ADDR_W-1:0] la);
    return {base[ADDR_W-1:OFF_W], la[ADDR_W-1:ADDR_W-IDX_W], 2'b00};
  endfunction

  // word address of the table entry, given the fetched directory entry
  function automatic logic [ADDR_W-1:0] tab_rd_addr(input logic [ADDR_W-1:0] pde,
                                                    input logic [ADDR_W-1:0] la);
    return {pde[ADDR_W-1:OFF_W], la[ADDR_W-IDX_W-1:OFF_W], 2'b00};
  endfunction

  function automatic logic entry_ok(input logic [ADDR_W-1:0] e);
    return e[0];
  endfunction

  function automatic logic [VPN_W-1:0] frame_of(input logic [ADDR_W-1:0] e);
    return e[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [VPN_W-1:0] page_of(input logic [ADDR_W-1:0] la);
    return la[ADDR_W-1:OFF_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_paddr(input logic [VPN_W-1:0] pfn,
                                                   input logic [ADDR_W-1:0] la);
    return {pfn, la[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/pgw_tcache.sv
module pgw_tcache
  import pgw_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [VPN_W-1:0] lk_pfn,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [VPN_W-1:0] fill_pfn
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [VPN_W-1:0]   key_q [ENTRIES];
  logic [VPN_W-1:0]   val_q [ENTRIES];
  logic [IW-1:0]      rr_q;
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] dup_vec;
  logic [IW-1:0]      victim;
  logic               has_free;
  logic               all_full;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign hit_vec[g] = vld_q[g] && (key_q[g] == lk_vpn);
    assign dup_vec[g] = vld_q[g] && (key_q[g] == fill_vpn);
  end

  assign lk_hit   = |hit_vec;
  assign all_full = &vld_q;

  always_comb begin
    lk_pfn = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hit_vec[i]) lk_pfn = lk_pfn | val_q[i];
    end
  end

  // lowest empty slot first, round-robin pointer only when full
  always_comb begin
    victim   = rr_q;
    has_free = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld_q[i] && !has_free) begin
        victim   = IW'(i);
        has_free = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      rr_q  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        key_q[i] <= '0;
        val_q[i] <= '0;
      end
    end else if (flush) begin
      vld_q <= '0;
    end else if (fill_en) begin
      vld_q[victim] <= 1'b1;
      key_q[victim] <= fill_vpn;
      val_q[victim] <= fill_pfn;
      if (all_full) begin
        if (rr_q == IW'(ENTRIES - 1)) rr_q <= '0;
        else                          rr_q <= rr_q + 1'b1;
      end
    end
  end

  // keys stay unique even when frames alias
  p_unique_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)) else $error("multiple slots hit");

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !lk_hit) else $error("hit after flush");

  p_fill_only_new_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !(|dup_vec)) else $error("fill duplicates a resident page");
endmodule

// File: rtl/pgw_walker.sv
module pgw_walker
  import pgw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] base,
  input  logic              flush,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_laddr,
  input  logic              lk_hit,
  input  logic [VPN_W-1:0]  lk_pfn,
  output logic              fill_en,
  output logic [VPN_W-1:0]  fill_vpn,
  output logic [VPN_W-1:0]  fill_pfn,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic              rsp_fault
);
  walk_st_e          st_q;
  logic [ADDR_W-1:0] la_q;
  logic [ADDR_W-1:0] pde_q;
  logic [ADDR_W-1:0] pa_q;
  logic              flt_q;

  // named events for the assertions
  logic acc;
  logic acc_hit;
  logic dir_bad;
  logic tab_done;

  assign req_ready = (st_q == ST_IDLE) && !flush;
  assign acc       = req_valid && req_ready;
  assign acc_hit   = acc && lk_hit;
  assign dir_bad   = (st_q == ST_DIR_WT) && mem_rvalid && !entry_ok(mem_rdata);
  assign tab_done  = (st_q == ST_TAB_WT) && mem_rvalid;

  assign mem_req  = (st_q == ST_DIR_RQ) || (st_q == ST_TAB_RQ);
  assign mem_addr = (st_q == ST_DIR_RQ) ? dir_rd_addr(base, la_q) : tab_rd_addr(pde_q, la_q);

  assign fill_en  = tab_done && entry_ok(mem_rdata) && !flush;
  assign fill_vpn = page_of(la_q);
  assign fill_pfn = frame_of(mem_rdata);

  assign rsp_valid = (st_q == ST_RSP);
  assign rsp_paddr = pa_q;
  assign rsp_fault = flt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      la_q  <= '0;
      pde_q <= '0;
      pa_q  <= '0;
      flt_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (acc) begin
            la_q <= req_laddr;
            if (lk_hit) begin
              pa_q  <= join_paddr(lk_pfn, req_laddr);
              flt_q <= 1'b0;
              st_q  <= ST_RSP;
            end else begin
              st_q <= ST_DIR_RQ;
            end
          end
        end
        ST_DIR_RQ: st_q <= ST_DIR_WT;
        ST_DIR_WT: begin
          if (mem_rvalid) begin
            if (entry_ok(mem_rdata)) begin
              pde_q <= mem_rdata;
              st_q  <= ST_TAB_RQ;
            end else begin
              pa_q  <= '0;
              flt_q <= 1'b1;
              st_q  <= ST_RSP;
            end
          end
        end
        ST_TAB_RQ: st_q <= ST_TAB_WT;
        ST_TAB_WT: begin
          if (mem_rvalid) begin
            if (entry_ok(mem_rdata)) begin
              pa_q  <= join_paddr(frame_of(mem_rdata), la_q);
              flt_q <= 1'b0;
            end else begin
              pa_q  <= '0;
              flt_q <= 1'b1;
            end
            st_q <= ST_RSP;
          end
        end
        ST_RSP: if (rsp_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  p_bad_dir_stops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dir_bad |=> rsp_valid && rsp_fault && !mem_req) else $error("walk went on after bad directory entry");

  p_no_fill_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> rsp_valid && !rsp_fault) else $error("fill on faulting walk");

  p_hit_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_hit |=> rsp_valid && !mem_req) else $error("hit did not answer next cycle");

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))
    else $error("response changed before acceptance");

  p_busy_refuses_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req) |-> !req_ready) else $error("request taken while busy");
endmodule

// File: rtl/pgw_xlate.sv
module pgw_xlate
  import pgw_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        base_we,
  input  logic [31:0] base_wdata,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_laddr,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_paddr,
  output logic        rsp_fault,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  logic [ADDR_W-1:0] base_q;
  logic              lk_hit;
  logic [VPN_W-1:0]  lk_pfn;
  logic              fill_en;
  logic [VPN_W-1:0]  fill_vpn;
  logic [VPN_W-1:0]  fill_pfn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       base_q <= '0;
    else if (base_we) base_q <= base_wdata;
  end

  pgw_tcache #(.ENTRIES(ENTRIES)) u_cache (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (base_we),
    .lk_vpn   (page_of(req_laddr)),
    .lk_hit   (lk_hit),
    .lk_pfn   (lk_pfn),
    .fill_en  (fill_en),
    .fill_vpn (fill_vpn),
    .fill_pfn (fill_pfn)
  );

  pgw_walker u_walk (
    .clk        (clk),
    .rst_n      (rst_n),
    .base       (base_q),
    .flush      (base_we),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_laddr  (req_laddr),
    .lk_hit     (lk_hit),
    .lk_pfn     (lk_pfn),
    .fill_en    (fill_en),
    .fill_vpn   (fill_vpn),
    .fill_pfn   (fill_pfn),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_paddr  (rsp_paddr),
    .rsp_fault  (rsp_fault)
  );

  p_base_write_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    base_we |-> !req_ready) else $error("request accepted during base write");
endmodule

// File: tb/test_pgw_xlate.sv
`timescale 1ns/1ps
module test_pgw_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_laddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_rvalid;
  logic [31:0] mem_rdata;

  always #2 clk = ~clk;

  pgw_xlate i_pgw_xlate (
    .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_laddr(req_laddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] cur_base = '0;

  typedef struct {
    logic [31:0] pa;
    logic        flt;
    int          nrd;
    string       tag;
  } exp_t;
  exp_t        exp_q [$];
  logic [31:0] rd_q  [$];
  int          rd_cnt = 0;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, expv);
    end
  endtask

  // memory: answers one cycle after the strobe
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= mem_req;
      mem_rdata  <= peek(mem_addr);
    end
  end

  // monitor: read addresses and responses, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (mem_req) begin
        rd_cnt++;
        if (rd_q.size() == 0) chk(0, "R1/R2 unexpected read", mem_addr, 32'h0);
        else begin
          logic [31:0] ea;
          ea = rd_q.pop_front();
          chk(mem_addr == ea, "R1/R2 read address", mem_addr, ea);
        end
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(0, "R10 unexpected response", rsp_paddr, 32'h0);
        else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(rsp_paddr == e.pa, {e.tag, " paddr"}, rsp_paddr, e.pa);
          chk(rsp_fault == e.flt, {e.tag, " fault"}, 32'(rsp_fault), 32'(e.flt));
          chk(rd_cnt == e.nrd, {e.tag, " read count"}, 32'(rd_cnt), 32'(e.nrd));
        end
        rd_cnt = 0;
      end
    end
  end

  // driver: works out the expected result from the tables and queues it
  task automatic xlate(input logic [31:0] la, input bit hit, input string tag, input bit wait_done = 1);
    exp_t        e;
    logic [31:0] a0, a1, pde, pte;
    a0  = {cur_base[31:12], la[31:22], 2'b00};
    pde = peek(a0);
    a1  = {pde[31:12], la[21:12], 2'b00};
    pte = peek(a1);
    e.tag = tag;
    if (!pde[0])      begin e.pa = '0; e.flt = 1'b1; e.nrd = 1; end
    else if (!pte[0]) begin e.pa = '0; e.flt = 1'b1; e.nrd = 2; end
    else              begin e.pa = {pte[31:12], la[11:0]}; e.flt = 1'b0; e.nrd = 2; end
    if (hit) e.nrd = 0;
    else begin
      rd_q.push_back(a0);
      if (e.nrd == 2) rd_q.push_back(a1);
    end
    exp_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1;
    req_laddr = la;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    req_laddr = 32'hDEAD_BEEF;
    if (wait_done) while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    base_we    = 1'b1;
    base_wdata = b;
    #1;
    chk(req_ready == 1'b0, "R8 ready low during base write", 32'(req_ready), 32'h0);
    @(negedge clk);
    base_we  = 1'b0;
    cur_base = b;
  endtask

  initial begin
    logic [31:0] hp;
    logic        hf;
    // space 0: directory at 0x0001_0000
    mem[32'h0001_0004] = 32'h0002_0001;            // dir 1 -> table 0x20000
    mem[32'h0001_000C] = 32'h0003_0001;            // dir 3 -> table 0x30000 (empty)
    for (int i = 0; i < 8; i++) mem[32'h0002_0000 + 32'(i * 4)] = {20'h00100 + 20'(i), 12'h001};
    mem[32'h0002_0004] = {20'h00101, 12'hE01};      // junk flag bits
    mem[32'h0002_0014] = {20'h00ABC, 12'h001};      // page 5 and 6 share a frame
    mem[32'h0002_0018] = {20'h00ABC, 12'h001};
    // space 1: directory at 0x0005_0000
    mem[32'h0005_0004] = 32'h0006_0001;
    mem[32'h0006_0000] = 32'h7777_7001;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R11 ready after reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R11 no response after reset", 32'(rsp_valid), 32'h0);
    chk(mem_req == 1'b0, "R11 no read after reset", 32'(mem_req), 32'h0);

    set_base(32'h0001_0000);
    xlate(32'h0040_1123, 0, "R11 R1 R2 first walk");
    xlate(32'h0040_1FFF, 1, "R6 hit new offset");
    xlate(32'h0080_0000, 0, "R3 bad directory");
    xlate(32'h0080_0000, 0, "R5 fault not cached dir");
    xlate(32'h00C0_0456, 0, "R4 bad table entry");
    xlate(32'h00C0_0456, 0, "R5 fault not cached tab");
    xlate(32'h0040_5010, 0, "R7 alias a fill");
    xlate(32'h0040_6020, 0, "R7 alias b fill");
    xlate(32'h0040_5ABC, 1, "R7 alias a hit");
    xlate(32'h0040_6DEF, 1, "R7 alias b hit");
    xlate(32'h0040_0000, 0, "R9 fourth slot fill");
    xlate(32'h0040_1000, 1, "R9 slot0 resident");
    xlate(32'h0040_5000, 1, "R9 slot1 resident");
    xlate(32'h0040_3000, 0, "R9 evict slot0");
    xlate(32'h0040_1000, 0, "R9 slot0 evicted, evict slot1");
    xlate(32'h0040_6000, 1, "R9 slot2 kept");
    xlate(32'h0040_5000, 0, "R9 slot1 evicted, evict slot2");
    xlate(32'h0040_0000, 1, "R9 slot3 kept");
    xlate(32'h0040_3000, 1, "R9 slot0 refill hit");
    xlate(32'h0040_6000, 0, "R9 slot2 evicted");

    // R10: hold a hit response
    rsp_ready = 1'b0;
    xlate(32'h0040_3444, 1, "R10 held response", 0);
    do begin @(negedge clk); #1; end while (!rsp_valid);
    hp = rsp_paddr;
    hf = rsp_fault;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(rsp_valid && rsp_paddr == hp && rsp_fault == hf, "R10 response stable", rsp_paddr, hp);
      chk(req_ready == 1'b0, "R10 ready low while held", 32'(req_ready), 32'h0);
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);

    // R8: switch address space
    set_base(32'h0005_0000);
    xlate(32'h0040_0123, 0, "R8 new base walk");
    xlate(32'h0040_3000, 0, "R8 old page not cached");
    xlate(32'h0040_0FFF, 1, "R8 hit in new space");

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0 && rd_q.size() == 0, "R10 all results seen", 32'(exp_q.size()), 32'h0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule